// File: doc/BRIEF.md
# Interrupt Polarity Normalizing Front-End

This block conditions a bank of raw interrupt lines so that a downstream interrupt controller, which understands only active-high levels and rising edges, can take any of them. Each line has its own 3-bit sense code that selects one of five sense types:

- active-high level
- active-low level
- rising edge
- falling edge
- both edges

Level lines come out high while asserted, with active-low lines inverted on the way. Edge lines come out as one-cycle high pulses: one per qualifying transition, and one per transition of either direction for the both-edges type.

Software programs the block through a small word-addressed register port. A bank of enable words holds one bit per line, and a configuration word per line holds its sense code. Every raw line is first resynchronized into the block clock through two flops. The line is then conditioned according to its code, gated by its enable bit, and registered before it leaves the block.

Rewriting a line's configuration while its input is steady must not produce a false event. For the cycle after the write, the edge result for that line is suppressed, and its history is taken from the current input.

Top module: `irq_polarity_norm`

## Requirements
- R1: During and after reset all enable bits read as zero, `irq_norm` is all zero and `reg_rdata` is zero.
- R2: Enable word k sits at byte address 0x10 + 4k and holds line 32k+b in bit b. It is written whole and reads back as written.
- R3: The configuration word for line p sits at byte address 0x110 + 4p. A write stores `reg_wdata[2:0]`, and a read returns that code zero-extended to 32 bits.
- R4: A read of any address outside the enable and configuration ranges, or with `reg_addr[1:0]` not zero, returns zero. A write to such an address changes nothing.
- R5: A line with code 3'b100 (active-high level) drives its output equal to its resynchronized input.
- R6: A line with code 3'b000 (active-low level) drives its output equal to the inverse of its resynchronized input.
- R7: A line with code 3'b110 (rising edge) gives a one-cycle output pulse for each low-to-high input transition and nothing for high-to-low.
- R8: A line with code 3'b010 (falling edge) gives a one-cycle output pulse for each high-to-low input transition and nothing for low-to-high.
- R9: A line with code 3'b111 (both edges) gives a one-cycle output pulse for every input transition.
- R10: A line whose code is any other value (3'b001, 3'b011, 3'b101) keeps its output low whatever its input does.
- R11: A line whose enable bit is clear keeps its output low. An enable change takes effect at the output one clock edge after the write edge.
- R12: In the cycle after a configuration write to a line, that line produces no edge pulse, so reprogramming over a steady input raises no false event.
- R13: An input change reaches the output on the third rising clock edge after the change: two synchronizer flops and one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (12) | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd`, zero otherwise |
| irq_raw | input | NUM_PINS (256) | Raw asynchronous interrupt lines |
| irq_norm | output | NUM_PINS (256) | Normalized interrupt lines toward the parent controller |

## Verification
Each result falls due a fixed number of rising edges after its stimulus:

- A register write takes effect on the edge that samples it.
- Read data is registered on the edge that samples `reg_rd`.
- An enable change reaches `irq_norm` one edge after the write edge.
- A raw input change reaches `irq_norm` on the third edge.

The bench drives every input on a falling edge and counts rising edges before sampling on the following falling edge. For each input step it checks the output after the second edge (still old), after the third edge (new) and after the fourth edge (held for levels, gone for pulses). The write-cycle edge mask is tested by timing an input rise so that its edge would otherwise appear exactly in the masked cycle.

// File: rtl/irq_norm_pkg.sv
package irq_norm_pkg;

  // Sense codes held in each line's configuration word.
  localparam logic [2:0] SENSE_LVL_LO = 3'b000;
  localparam logic [2:0] SENSE_FALL   = 3'b010;
  localparam logic [2:0] SENSE_LVL_HI = 3'b100;
  localparam logic [2:0] SENSE_RISE   = 3'b110;
  localparam logic [2:0] SENSE_BOTH   = 3'b111;

  // Byte offsets of the two register ranges.
  localparam int EN_BANK_OFS  = 'h010;
  localparam int CFG_BANK_OFS = 'h110;

  localparam int DATA_W = 32;

  function automatic logic is_edge_code(input logic [2:0] c);
    return (c == SENSE_RISE) || (c == SENSE_FALL) || (c == SENSE_BOTH);
  endfunction

endpackage

// File: rtl/irq_norm_sync.sv
module irq_norm_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

endmodule

// File: rtl/irq_norm_regs.sv
module irq_norm_regs
  import irq_norm_pkg::*;
#(
  parameter int NUM_PINS = 256,
  parameter int ADDR_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_PINS-1:0]  en_flat,
  output logic [3*NUM_PINS-1:0] cfg_flat,
  output logic [NUM_PINS-1:0]  cfg_fresh
);

  localparam int NUM_WORDS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int WIDX_W    = ADDR_W - 2;
  localparam int EN_WORD0  = EN_BANK_OFS / 4;
  localparam int CFG_WORD0 = CFG_BANK_OFS / 4;

  logic [WIDX_W-1:0] word_idx;
  logic              aligned;
  logic              en_hit;
  logic              cfg_hit;
  logic [WIDX_W-1:0] en_off;
  logic [WIDX_W-1:0] cfg_off;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign en_off   = word_idx - WIDX_W'(EN_WORD0);
  assign cfg_off  = word_idx - WIDX_W'(CFG_WORD0);
  assign en_hit   = aligned && (word_idx >= WIDX_W'(EN_WORD0)) &&
                    (word_idx < WIDX_W'(EN_WORD0 + NUM_WORDS));
  assign cfg_hit  = aligned && (word_idx >= WIDX_W'(CFG_WORD0)) &&
                    (word_idx < WIDX_W'(CFG_WORD0 + NUM_PINS));

  logic [DATA_W-1:0] en_words [NUM_WORDS];
  logic [2:0]        cfg_q    [NUM_PINS];

  // Enable bank, one word per 32 lines.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_en_word
    always_ff @(posedge clk) begin
      if (rst) begin
        en_words[w] <= '0;
      end else if (wr && en_hit && (en_off == WIDX_W'(w))) begin
        en_words[w] <= wdata;
      end
    end
  end

  // Per-line sense codes and the one-cycle "just written" flag.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
    logic hit_p;
    assign hit_p = wr && cfg_hit && (cfg_off == WIDX_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[p]     <= SENSE_LVL_LO;
        cfg_fresh[p] <= 1'b0;
      end else begin
        cfg_fresh[p] <= hit_p;
        if (hit_p) begin
          cfg_q[p] <= wdata[2:0];
        end
      end
    end

    assign cfg_flat[3*p +: 3] = cfg_q[p];
    assign en_flat[p]         = en_words[p / DATA_W][p % DATA_W];
  end

  // Read multiplexer.
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (en_hit && (en_off == WIDX_W'(w))) begin
        rd_next = en_words[w];
      end
    end
    for (int p = 0; p < NUM_PINS; p++) begin
      if (cfg_hit && (cfg_off == WIDX_W'(p))) begin
        rd_next = {{(DATA_W-3){1'b0}}, cfg_q[p]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd ? rd_next : '0;
    end
  end

  // R1: the enable bank is empty once reset has been seen.
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (en_flat == '0));

  // R4: reads outside both ranges, or misaligned, return zero.
  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd && !en_hit && !cfg_hit) |=> (rdata == '0));

endmodule

// File: rtl/irq_norm_lane.sv
module irq_norm_lane
  import irq_norm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_in,
  input  logic [2:0] cfg,
  input  logic       en,
  input  logic       fresh,
  output logic       irq_out
);

  logic hist;
  logic rise_ev;
  logic fall_ev;
  logic cond;

  assign rise_ev = sync_in & ~hist & ~fresh;
  assign fall_ev = ~sync_in & hist & ~fresh;

  always_comb begin
    case (cfg)
      SENSE_LVL_HI: cond = sync_in;
      SENSE_LVL_LO: cond = ~sync_in;
      SENSE_RISE:   cond = rise_ev;
      SENSE_FALL:   cond = fall_ev;
      SENSE_BOTH:   cond = rise_ev | fall_ev;
      default:      cond = 1'b0;
    endcase
  end

  // The history always reloads from the present input, so after a
  // configuration write the detector starts from the current level.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      hist    <= sync_in;
      irq_out <= en & cond;
    end
  end

  // R11: a disabled line is quiet on the following edge.
  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_out);

  // R10: undefined codes never raise the output.
  assert_bad_code_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg != SENSE_LVL_HI && cfg != SENSE_LVL_LO && !is_edge_code(cfg))
      |=> !irq_out);

  // R12: no edge pulse in the cycle after a configuration write.
  assert_fresh_no_edge_R12: assert property (@(posedge clk) disable iff (rst)
    (fresh && is_edge_code(cfg)) |=> !irq_out);

  // R7: a rising-edge pulse lasts exactly one cycle.
  assert_rise_single_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_out && cfg == SENSE_RISE && $stable(cfg)) |=> !irq_out);

  // R8: a falling-edge pulse lasts exactly one cycle.
  assert_fall_single_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_out && cfg == SENSE_FALL && $stable(cfg)) |=> !irq_out);

endmodule

// File: rtl/irq_polarity_norm.sv
module irq_polarity_norm
  import irq_norm_pkg::*;
#(
  parameter int NUM_PINS = 256,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] irq_raw,
  output logic [NUM_PINS-1:0] irq_norm
);

  logic [NUM_PINS-1:0]   en_flat;
  logic [3*NUM_PINS-1:0] cfg_flat;
  logic [NUM_PINS-1:0]   cfg_fresh;
  logic [NUM_PINS-1:0]   raw_sync;

  irq_norm_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr),
    .rd        (reg_rd),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .en_flat   (en_flat),
    .cfg_flat  (cfg_flat),
    .cfg_fresh (cfg_fresh)
  );

  irq_norm_sync #(
    .WIDTH (NUM_PINS)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_raw),
    .q   (raw_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
    irq_norm_lane u_lane (
      .clk     (clk),
      .rst     (rst),
      .sync_in (raw_sync[p]),
      .cfg     (cfg_flat[3*p +: 3]),
      .en      (en_flat[p]),
      .fresh   (cfg_fresh[p]),
      .irq_out (irq_norm[p])
    );
  end

endmodule

// File: tb/test_irq_polarity_norm.sv
module test_irq_polarity_norm;

  localparam int NP = 256;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] irq_raw = '0;
  logic [NP-1:0] irq_norm;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_polarity_norm #(.NUM_PINS(NP), .ADDR_W(AW)) i_irq_polarity_norm (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_raw(irq_raw), .irq_norm(irq_norm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [AW-1:0] cfg_addr(input int p);
    return AW'(32'h110 + 4 * p);
  endfunction

  // Step one line; check output after edges 2, 3 and 4.
  task automatic pin_step(input int p, input bit v, input bit e2, input bit e3,
                          input bit e4, input string tag);
    irq_raw[p] = v;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk({tag, " R13 edge2"}, 32'(irq_norm[p]), 32'(e2));
    @(posedge clk); @(negedge clk);
    chk({tag, " edge3"}, 32'(irq_norm[p]), 32'(e3));
    @(posedge clk); @(negedge clk);
    chk({tag, " edge4"}, 32'(irq_norm[p]), 32'(e4));
  endtask

  task automatic quiet(input int p, input int n, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_norm[p]) seen = 1'b1;
    end
    chk(tag, 32'(seen), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 outputs", 32'(|irq_norm), 32'd0);
    chk("R1 rdata", reg_rdata, 32'd0);
    rd_chk(12'h010, 32'd0, "R1 enable word0");
    rd_chk(12'h02C, 32'd0, "R1 enable word7");
  endtask

  task automatic t_regs;
    wr_reg(12'h014, 32'hA5A5_0001);
    rd_chk(12'h014, 32'hA5A5_0001, "R2 readback");
    wr_reg(12'h014, 32'h0);
    wr_reg(cfg_addr(37), 32'hFFFF_FFF6);
    rd_chk(cfg_addr(37), 32'h6, "R3 code zero-extended");
    wr_reg(cfg_addr(37), 32'h0);
    rd_chk(cfg_addr(255), 32'h0, "R3 last line reset code");
    rd_chk(12'h000, 32'h0, "R4 below enables");
    rd_chk(12'h030, 32'h0, "R4 past enables");
    rd_chk(12'h510, 32'h0, "R4 past configs");
    wr_reg(12'h012, 32'hFFFF_FFFF);
    rd_chk(12'h010, 32'h0, "R4 misaligned write ignored");
    rd_chk(12'h112, 32'h0, "R4 misaligned read");
  endtask

  task automatic t_level;
    wr_reg(cfg_addr(0), 32'h4);
    wr_reg(cfg_addr(1), 32'h0);
    wr_reg(12'h010, 32'h3);
    @(posedge clk); @(negedge clk);
    chk("R6 low input asserted", 32'(irq_norm[1]), 32'd1);
    chk("R5 low input quiet", 32'(irq_norm[0]), 32'd0);
    pin_step(1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 rise");
    pin_step(0, 1'b1, 1'b0, 1'b1, 1'b1, "R5 rise");
    pin_step(0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 fall");
  endtask

  task automatic t_edges;
    wr_reg(cfg_addr(33), 32'h6);
    wr_reg(cfg_addr(34), 32'h2);
    wr_reg(12'h014, 32'h6);
    @(posedge clk); @(negedge clk);
    pin_step(33, 1'b1, 1'b0, 1'b1, 1'b0, "R7 rise pulse");
    pin_step(33, 1'b0, 1'b0, 1'b0, 1'b0, "R7 fall ignored");
    pin_step(34, 1'b1, 1'b0, 1'b0, 1'b0, "R8 rise ignored");
    pin_step(34, 1'b0, 1'b0, 1'b1, 1'b0, "R8 fall pulse");
  endtask

  task automatic t_dual;
    wr_reg(cfg_addr(255), 32'h7);
    wr_reg(12'h02C, 32'h8000_0000);
    @(posedge clk); @(negedge clk);
    pin_step(255, 1'b1, 1'b0, 1'b1, 1'b0, "R9 rise pulse");
    pin_step(255, 1'b0, 1'b0, 1'b1, 1'b0, "R9 fall pulse");
  endtask

  task automatic t_bad;
    wr_reg(cfg_addr(5), 32'h1);
    wr_reg(12'h010, 32'h23);
    pin_step(5, 1'b1, 1'b0, 1'b0, 1'b0, "R10 code 001 high");
    wr_reg(cfg_addr(5), 32'h5);
    quiet(5, 4, "R10 code 101 high input");
    pin_step(5, 1'b0, 1'b0, 1'b0, 1'b0, "R10 code 101 fall");
    wr_reg(cfg_addr(5), 32'h3);
    pin_step(5, 1'b1, 1'b0, 1'b0, 1'b0, "R10 code 011 rise");
  endtask

  task automatic t_enable;
    pin_step(0, 1'b1, 1'b0, 1'b1, 1'b1, "R5 level held");
    wr_reg(12'h010, 32'h22);
    @(posedge clk); @(negedge clk);
    chk("R11 disable takes effect", 32'(irq_norm[0]), 32'd0);
    wr_reg(12'h010, 32'h23);
    @(posedge clk); @(negedge clk);
    chk("R11 re-enable restores level", 32'(irq_norm[0]), 32'd1);
    wr_reg(12'h014, 32'h0);
    pin_step(33, 1'b1, 1'b0, 1'b0, 1'b0, "R11 disabled rising line");
    pin_step(33, 1'b0, 1'b0, 1'b0, 1'b0, "R11 disabled falling");
    wr_reg(12'h014, 32'h6);
  endtask

  task automatic t_phantom;
    // Line 34 falling-edge, input high and steady, recoded to rising.
    pin_step(34, 1'b1, 1'b0, 1'b0, 1'b0, "R8 setup rise");
    wr_reg(cfg_addr(34), 32'h6);
    quiet(34, 5, "R12 recode over steady high");
    // Line 1 active-low, input high: recode to falling edge.
    wr_reg(cfg_addr(1), 32'h2);
    quiet(1, 5, "R12 recode level to edge");
    // Input rise on line 33 timed to land in the masked cycle.
    irq_raw[33] = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_reg(cfg_addr(33), 32'h6);
    @(posedge clk); @(negedge clk);
    chk("R12 edge masked after write", 32'(irq_norm[33]), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R12 no late pulse", 32'(irq_norm[33]), 32'd0);
    pin_step(33, 1'b0, 1'b0, 1'b0, 1'b0, "R7 fall after mask");
    pin_step(33, 1'b1, 1'b0, 1'b1, 1'b0, "R7 detector resumes");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_regs;
    t_level;
    t_edges;
    t_dual;
    t_bad;
    t_enable;
    t_phantom;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule